// File: doc/BRIEF.md
# Two-Phase Hardware Barrier

This block lets a group of parallel agents meet at a common point before any of them moves on. Each agent pulses its arrive strobe when it reaches the meeting point and then waits. The block tallies arrivals. Only when the last expected agent has been counted does it raise a proceed output to every counted agent at once.

Each agent then pulses its depart strobe. The block tallies these departures back down. It admits no arrival for the next round until every agent of the current round has left. An agent that hurries back before the others have drained keeps its arrival parked until the round closes, and is then counted in the next round.

Internally there are two gates that are never open together: an entry gate, which admits arrivals, and an exit gate, which admits departures. A single up/down counter sits between them. The number of participating agents is a configuration input. Agents whose index lies at or above that number take no part.

Top module: `barrier_sync`

## Requirements
- R1: After reset the count is zero, the entry gate is open, the exit gate is closed, and every `proceed` bit is 0.
- R2: At every cycle after reset exactly one of the two gates is open.
- R3: Each accepted arrival raises the count by one. `proceed` stays all-zero until the count equals the participant total. It becomes equal to the mask of counted agents on the clock edge that accepts the final arrival.
- R4: While the exit gate is open, a depart strobe from a counted agent clears that agent's `proceed` bit on the edge that accepts it. The edge that accepts the last departure closes the exit gate and reopens the entry gate, so a full new round can then be gathered.
- R5: At most one arrival or departure is accepted per clock edge. Among simultaneous or pending requests, the lowest agent index is served first. Consequently, when all agents depart in one cycle, their `proceed` bits fall one per edge, starting from bit 0.
- R6: An arrival strobe from an agent that has already departed, made while the exit gate is still open, is not lost. It is held and counted after the entry gate reopens, at most one edge per held request.
- R7: An arrive strobe from an agent that is already counted in the current round, or that already has an arrival held, has no effect on the count.
- R8: `cfg_parts` selects the participant total; a value of 0 or above `NUM_PARTS` means `NUM_PARTS`. Strobes from agents with index at or above the total are ignored, and their `proceed` bits stay 0.
- R9: Depart strobes made while the entry gate is open have no effect on the count or on which agents are counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_parts | input | $clog2(NUM_PARTS+1) | Participant total; 0 or above NUM_PARTS selects NUM_PARTS; hold steady between resets |
| arrive | input | NUM_PARTS | Per-agent arrival strobe, one cycle per request |
| depart | input | NUM_PARTS | Per-agent departure strobe, one cycle per request |
| proceed | output | NUM_PARTS | Per-agent release, high while the agent is counted and the exit gate is open |

## Verification
A count that is wrong by even one shows at the ports within a single round. `proceed` would then rise one edge early or late, or not at all, and the exact release edge is checked for every arrival mask and every participant total. A wrong serving order or a lost held request shows as a `proceed` bit falling out of sequence during the drain. It also shows as a following round that never completes. Both are visible within a few cycles of the stimulus. A gate that reopens too soon lets a held arrival leak into the round being drained, which changes the release pattern of the next round.

// File: rtl/barrier_sync_pkg.sv
package barrier_sync_pkg;

    // Gate state: bit 0 = entry gate open, bit 1 = exit gate open.
    typedef enum logic [1:0] {
        GATE_ENTRY = 2'b01,
        GATE_EXIT  = 2'b10
    } gate_e;

    // Kind of event accepted on the current edge.
    typedef struct packed {
        logic take;   // one arrival accepted
        logic leave;  // one departure accepted
    } svc_t;

    // Gate transition for one accepted event.
    function automatic gate_e gate_step(gate_e cur, svc_t svc,
                                        logic at_full, logic at_empty);
        gate_e nxt;
        nxt = cur;
        if (cur == GATE_ENTRY && svc.take && at_full) begin
            nxt = GATE_EXIT;
        end else if (cur == GATE_EXIT && svc.leave && at_empty) begin
            nxt = GATE_ENTRY;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bs_pick.sv
// Fixed-priority one-hot picker: lowest set request wins.
module bs_pick #(
    parameter int W = 4
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant
);
    logic [W:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
endmodule

// File: rtl/bs_tally.sv
// Up/down participant counter and the two-gate state.
module bs_tally
    import barrier_sync_pkg::*;
#(
    parameter int NUM_PARTS = 4,
    parameter int CW        = $clog2(NUM_PARTS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  svc_t          svc,
    input  logic [CW-1:0] total,
    output logic [CW-1:0] count,
    output gate_e         gate
);
    logic [CW:0]   count_wide;
    logic          at_full;
    logic          at_empty;
    logic [CW-1:0] count_nxt;
    gate_e         gate_nxt;

    assign count_wide = {1'b0, count};
    assign at_full    = (count_wide + 1'b1) == {1'b0, total};
    assign at_empty   = (count == CW'(1));

    always_comb begin
        count_nxt = count;
        if (svc.take) begin
            count_nxt = count + CW'(1);
        end else if (svc.leave) begin
            count_nxt = count - CW'(1);
        end
        gate_nxt = gate_step(gate, svc, at_full, at_empty);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            gate  <= GATE_ENTRY;
        end else begin
            count <= count_nxt;
            gate  <= gate_nxt;
        end
    end
endmodule

// File: rtl/bs_roster.sv
// Per-agent bookkeeping: counted mask plus held arrivals and departures.
module bs_roster
    import barrier_sync_pkg::*;
#(
    parameter int NUM_PARTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PARTS-1:0] arrive,
    input  logic [NUM_PARTS-1:0] depart,
    input  logic [NUM_PARTS-1:0] active,
    input  gate_e                gate,
    input  logic [NUM_PARTS-1:0] grant,
    output logic [NUM_PARTS-1:0] req,
    output logic [NUM_PARTS-1:0] arrived
);
    logic [NUM_PARTS-1:0] held_arr;
    logic [NUM_PARTS-1:0] held_dep;
    logic [NUM_PARTS-1:0] new_arr;
    logic [NUM_PARTS-1:0] new_dep;
    logic [NUM_PARTS-1:0] want_arr;
    logic [NUM_PARTS-1:0] want_dep;
    logic [NUM_PARTS-1:0] arrived_nxt;
    logic [NUM_PARTS-1:0] held_arr_nxt;
    logic [NUM_PARTS-1:0] held_dep_nxt;
    logic                 entry_open;
    logic                 exit_open;

    assign entry_open = (gate == GATE_ENTRY);
    assign exit_open  = (gate == GATE_EXIT);

    // An arrival counts only from an active agent that is not already counted.
    assign new_arr  = arrive & ~arrived & active;
    // A departure counts only from a counted agent while the exit gate is open.
    assign new_dep  = depart & arrived & {NUM_PARTS{exit_open}};
    assign want_arr = held_arr | new_arr;
    assign want_dep = held_dep | new_dep;
    assign req      = entry_open ? want_arr : want_dep;

    always_comb begin
        if (entry_open) begin
            arrived_nxt  = arrived | grant;
            held_arr_nxt = want_arr & ~grant;
            held_dep_nxt = want_dep;
        end else begin
            arrived_nxt  = arrived & ~grant;
            held_arr_nxt = want_arr;
            held_dep_nxt = want_dep & ~grant;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arrived  <= '0;
            held_arr <= '0;
            held_dep <= '0;
        end else begin
            arrived  <= arrived_nxt;
            held_arr <= held_arr_nxt;
            held_dep <= held_dep_nxt;
        end
    end
endmodule

// File: rtl/barrier_sync.sv
module barrier_sync
    import barrier_sync_pkg::*;
#(
    parameter int NUM_PARTS = 4,
    localparam int CW       = $clog2(NUM_PARTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CW-1:0]        cfg_parts,
    input  logic [NUM_PARTS-1:0] arrive,
    input  logic [NUM_PARTS-1:0] depart,
    output logic [NUM_PARTS-1:0] proceed
);
    logic [CW-1:0]        eff_total;
    logic [NUM_PARTS-1:0] active;
    logic [NUM_PARTS-1:0] req;
    logic [NUM_PARTS-1:0] grant;
    logic [NUM_PARTS-1:0] arrived;
    logic [CW-1:0]        count;
    gate_e                gate;
    svc_t                 svc;

    assign eff_total = (cfg_parts == '0 || cfg_parts > CW'(NUM_PARTS))
                       ? CW'(NUM_PARTS) : cfg_parts;

    for (genvar i = 0; i < NUM_PARTS; i++) begin : g_active
        assign active[i] = CW'(i) < eff_total;
    end

    assign svc.take  = (gate == GATE_ENTRY) && (|grant);
    assign svc.leave = (gate == GATE_EXIT)  && (|grant);

    bs_roster #(.NUM_PARTS(NUM_PARTS)) u_roster (
        .clk     (clk),
        .rst     (rst),
        .arrive  (arrive),
        .depart  (depart),
        .active  (active),
        .gate    (gate),
        .grant   (grant),
        .req     (req),
        .arrived (arrived)
    );

    bs_pick #(.W(NUM_PARTS)) u_pick (
        .req   (req),
        .grant (grant)
    );

    bs_tally #(.NUM_PARTS(NUM_PARTS), .CW(CW)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .svc   (svc),
        .total (eff_total),
        .count (count),
        .gate  (gate)
    );

    assign proceed = arrived & {NUM_PARTS{gate == GATE_EXIT}};
endmodule

// File: rtl/bs_check.sv
module bs_check #(
    parameter int NUM_PARTS = 4,
    parameter int CW        = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           gate,
    input logic [CW-1:0]        count,
    input logic [CW-1:0]        total,
    input logic [NUM_PARTS-1:0] arrived,
    input logic [NUM_PARTS-1:0] active,
    input logic [NUM_PARTS-1:0] proceed
);
    // R2: exactly one gate open
    p_gate_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(gate) == 1);

    // R3: counter never passes the participant total
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        count <= total);

    // R3: exit gate opens only with a full count
    p_open_full_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(gate[1]) |-> count == total);

    // R4: exit gate closes only when everyone has left
    p_close_empty_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(gate[1]) |-> (count == '0 && arrived == '0));

    // R5: one agent changes status per edge
    p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(arrived ^ $past(arrived)) <= 1);

    // R5: counter agrees with the counted mask
    p_count_tracks_r5: assert property (@(posedge clk) disable iff (rst)
        int'(count) == $countones(arrived));

    // R8: inactive agents are never released
    p_inactive_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (proceed & ~active) == '0);
endmodule

bind barrier_sync bs_check #(.NUM_PARTS(NUM_PARTS), .CW(CW)) u_check (
    .clk     (clk),
    .rst     (rst),
    .gate    (gate),
    .count   (count),
    .total   (eff_total),
    .arrived (arrived),
    .active  (active),
    .proceed (proceed)
);

// File: tb/barrier_sync_bench.sv
module barrier_sync_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int CW         = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cfg_parts = '0;
    logic [N-1:0]  arrive = '0;
    logic [N-1:0]  depart = '0;
    logic [N-1:0]  proceed;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    barrier_sync #(.NUM_PARTS(N)) u_barrier_sync (
        .clk       (clk),
        .rst       (rst),
        .cfg_parts (cfg_parts),
        .arrive    (arrive),
        .depart    (depart),
        .proceed   (proceed)
    );

    task automatic chk(string tag, logic [N-1:0] exp);
        vectors++;
        if (proceed !== exp) begin
            fails++;
            $display("FAIL %s: proceed=%b expected %b at %0t", tag, proceed, exp, $time);
        end
    endtask

    task automatic do_reset(logic [CW-1:0] cfg);
        rst = 1'b1; cfg_parts = cfg; arrive = '0; depart = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Pulse arrivals, then expect release exactly after the n-th edge.
    task automatic gather(string tag, logic [N-1:0] m, int n, logic [N-1:0] fin);
        arrive = m;
        @(negedge clk);
        arrive = '0;
        for (int e = 1; e <= n; e++) begin
            if (e > 1) @(negedge clk);
            chk(tag, (e == n) ? fin : '0);
        end
    endtask

    // All counted agents depart at once: bits fall lowest first (R5), gate reopens (R4).
    task automatic drain(int t, logic [N-1:0] act);
        depart = act;
        @(negedge clk);
        depart = '0;
        for (int j = 1; j <= t; j++) begin
            if (j > 1) @(negedge clk);
            chk("R5 drain order", act & ~((N'(1) << j) - N'(1)));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // Sweep every total and every simultaneous arrival mask.
        for (int t = 1; t <= N; t++) begin
            for (int m = 1; m < (1 << N); m++) begin
                logic [N-1:0] act;
                int k;
                act = N'((1 << t) - 1);
                do_reset(CW'(t));
                chk("R1 reset", '0);
                k = $countones(N'(m) & act);
                if (k == 0) begin
                    arrive = N'(m);
                    @(negedge clk);
                    arrive = '0;
                    chk("R8 inactive arrivals", '0);
                end else begin
                    gather("R3 release edge", N'(m), k, (k == t) ? act : '0);
                end
                if (k < t) begin
                    // re-strobe everyone: already-counted ones are duplicates (R7)
                    gather("R7 duplicate ignored", act, t - k, act);
                end
                drain(t, act);
                gather("R4 reopen", act, t, act);
                drain(t, act);
            end
        end

        // R8: out-of-range totals mean the full width
        do_reset('0);
        gather("R8 total zero", {N{1'b1}}, N, {N{1'b1}});
        do_reset(CW'(7));
        gather("R8 total large", {N{1'b1}}, N, {N{1'b1}});

        // R9: departures while gathering have no effect
        do_reset(CW'(2));
        depart = 4'b0011; @(negedge clk); depart = '0;
        chk("R9 early depart", '0);
        gather("R9 first arrival", 4'b0001, 1, '0);
        depart = 4'b0001; @(negedge clk); depart = '0;
        chk("R9 depart while gathering", '0);
        gather("R9 completes on time", 4'b0010, 1, 4'b0011);

        // R6: early re-arrival held while exit gate is open
        do_reset(CW'(2));
        gather("R6 setup", 4'b0011, 2, 4'b0011);
        depart = 4'b0001; @(negedge clk); depart = '0;
        chk("R4 single depart", 4'b0010);
        arrive = 4'b0001; @(negedge clk); arrive = '0;
        chk("R6 held not counted", 4'b0010);
        depart = 4'b0010; @(negedge clk); depart = '0;
        chk("R4 last depart", '0);
        @(negedge clk);
        chk("R6 held admitted", '0);
        gather("R6 held arrival counted", 4'b0010, 1, 4'b0011);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule